// File: doc/BRIEF.md
# Synchronous FIFO with programmable thresholds

A single-clock first-in/first-out buffer, 9 bits wide by default, with a depth set by parameter. The default is 512 words, and any power of two from 512 to 4096 is intended. Internal ring pointers advance on every accepted write and read, so the user supplies no addresses. Accepted reads load the oldest word into a registered output. Four active-low status flags are combinational functions of the stored word count: empty, almost-empty, full and almost-full. The two almost thresholds come from offset inputs, which an external offset register bank normally drives.

The second write-enable pin (`wr_en2_i`) is sampled on each clock while reset is held low, and the last level sampled becomes the operating mode.

- **Dual-enable mode (pin HIGH during reset):** the pin is a second write qualifier.
- **Load mode (pin LOW during reset):** the pin is an active-low load strobe for the external offset bank. Cycles that address that bank raise `ofs_wr_o` or `ofs_rd_o`, and they leave the FIFO contents untouched.

Top module: `sync_fifo_thresh`

## Requirements
- R1: While reset is low and after its release with no traffic, `data_o` is 0, `empty_no` is 0, `almost_empty_no` is 0, `full_no` is 1 and `almost_full_no` is 1.
- R2: With `wr_en2_i` HIGH during reset (dual-enable mode), a word is written only when `wr_en1_ni` is 0 and `wr_en2_i` is 1. With `wr_en1_ni` 0 and `wr_en2_i` 0 there is no write, and `ofs_wr_o` and `ofs_rd_o` stay 0 in this mode.
- R3: With `wr_en2_i` LOW during reset (load mode), a cycle with `wr_en1_ni` 0 and `wr_en2_i` 1 writes a word. A cycle with `wr_en1_ni` 0 and `wr_en2_i` 0 drives `ofs_wr_o` to 1 in that cycle and writes no word.
- R4: On a clock edge where both read enables are 0 and the FIFO holds data, `data_o` takes the oldest stored word. If either read enable is 1, `data_o` keeps its value.
- R5: A read while empty leaves `data_o` and the flags unchanged. A write while full is discarded and the stored words are not overwritten.
- R6: `empty_no` is 0 exactly when the stored count is 0.
- R7: `almost_full_no` is 0 exactly when the count is at least DEPTH − `af_ofs_i`.
- R8: `almost_empty_no` is 1 exactly when the count is at least `ae_ofs_i` + 1.
- R9: `full_no` is 0 exactly when the count equals DEPTH.
- R10: In load mode, a cycle with `wr_en2_i` 0 and both read enables 0 drives `ofs_rd_o` to 1 in that cycle, reads no word and leaves `data_o` unchanged.
- R11: A simultaneous accepted read and write leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; also the window in which the mode is sampled |
| wr_en1_ni | input | 1 | Primary write enable, active low |
| wr_en2_i | input | 1 | Second write enable (dual-enable mode) or active-low offset load strobe (load mode) |
| rd_en1_ni | input | 1 | Read enable 1, active low |
| rd_en2_ni | input | 1 | Read enable 2, active low |
| data_i | input | DATA_W | Write data |
| ae_ofs_i | input | AW | Almost-empty offset N |
| af_ofs_i | input | AW | Almost-full offset N |
| data_o | output | DATA_W | Registered read data |
| ofs_wr_o | output | 1 | Offset-bank write strobe (load mode only) |
| ofs_rd_o | output | 1 | Offset-bank read strobe (load mode only) |
| empty_no | output | 1 | Empty flag, active low |
| almost_empty_no | output | 1 | Almost-empty flag, active low |
| full_no | output | 1 | Full flag, active low |
| almost_full_no | output | 1 | Almost-full flag, active low |

## Verification
The hardest states to reach from the ports are the top of the buffer and the load-mode offset cycles. To reach the top, the stimulus writes a full buffer of distinct words. It then tries one more write and a combined read-plus-write at the full boundary, and drains everything, so that any overwrite shows up as a wrong word out. The offset cycles need a second reset with the second write-enable pin held low. Offset-write and offset-read cycles are then mixed with real traffic, and the count and `data_o` are checked to show that neither kind of offset cycle touched the stored words. Extreme offsets (0 and DEPTH − 2) move the threshold boundaries down to the first few words.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  typedef enum logic {
    MODE_LOAD = 1'b0,
    MODE_DUAL = 1'b1
  } wmode_e;
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
  import sfifo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en1_ni,
  input  logic wr_en2_i,
  input  logic rd_en1_ni,
  input  logic rd_en2_ni,
  output logic wr_req_o,
  output logic rd_req_o,
  output logic ofs_wr_o,
  output logic ofs_rd_o
);
  wmode_e mode_q;
  logic   load_sel;
  logic   rd_both;

  // mode follows the pin while reset is held, frozen afterwards
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= wmode_e'(wr_en2_i);
  end

  assign load_sel = rst_ni && (mode_q == MODE_LOAD) && !wr_en2_i;
  assign rd_both  = !rd_en1_ni && !rd_en2_ni;

  assign wr_req_o = rst_ni && !wr_en1_ni && wr_en2_i;
  assign rd_req_o = rst_ni && rd_both && !load_sel;
  assign ofs_wr_o = load_sel && !wr_en1_ni;
  assign ofs_rd_o = load_sel && rd_both;

  p_ofs_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_wr_o |-> !wr_req_o);
  p_ofs_rd_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_rd_o |-> !rd_req_o);
  p_dual_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_DUAL) |-> !(ofs_wr_o || ofs_rd_o));
endmodule

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [AW:0]   count_o
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0] wr_ptr_q, rd_ptr_q;
  logic        full, empty;

  assign count_o = wr_ptr_q - rd_ptr_q;
  assign full    = (count_o == FULL_CNT);
  assign empty   = (count_o == '0);
  assign push_o  = wr_req_i && !full;
  assign pop_o   = rd_req_i && !empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_o) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_o)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  assign wr_addr_o = wr_ptr_q[AW-1:0];
  assign rd_addr_o = rd_ptr_q[AW-1:0];

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  p_full_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_req_i && !rd_req_i) |=> $stable(wr_ptr_q));
  p_empty_block_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty && rd_req_i && !wr_req_i) |=> $stable(count_o));
  p_rw_keep_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && pop_o) |=> $stable(count_o));
endmodule

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_addr_i] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (pop_i) data_o <= mem_q[rd_addr_i];
  end

  p_hold_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_i |=> $stable(data_o));
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW:0]   count_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i,
  output logic          empty_no,
  output logic          almost_empty_no,
  output logic          full_no,
  output logic          almost_full_no
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW:0] ae_thr, af_thr;

  assign ae_thr = {1'b0, ae_ofs_i} + 1'b1;
  assign af_thr = FULL_CNT - {1'b0, af_ofs_i};

  assign empty_no        = (count_i != '0);
  assign almost_empty_no = (count_i >= ae_thr);
  assign full_no         = (count_i != FULL_CNT);
  assign almost_full_no  = !(count_i >= af_thr);

  p_full_implies_af_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !full_no |-> !almost_full_no);
  p_empty_implies_ae_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no);
  p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!full_no && !empty_no));
  p_ae_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(almost_empty_no) |-> empty_no);
endmodule

// File: rtl/sync_fifo_thresh.sv
module sync_fifo_thresh #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en1_ni,
  input  logic              wr_en2_i,
  input  logic              rd_en1_ni,
  input  logic              rd_en2_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AW-1:0]     ae_ofs_i,
  input  logic [AW-1:0]     af_ofs_i,
  output logic [DATA_W-1:0] data_o,
  output logic              ofs_wr_o,
  output logic              ofs_rd_o,
  output logic              empty_no,
  output logic              almost_empty_no,
  output logic              full_no,
  output logic              almost_full_no
);
  logic          wr_req, rd_req, push, pop;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [AW:0]   count;

  sfifo_ctrl u_ctrl (
    .clk_i, .rst_ni, .wr_en1_ni, .wr_en2_i, .rd_en1_ni, .rd_en2_ni,
    .wr_req_o(wr_req), .rd_req_o(rd_req), .ofs_wr_o, .ofs_rd_o
  );

  sfifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni, .wr_req_i(wr_req), .rd_req_i(rd_req),
    .push_o(push), .pop_o(pop), .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .count_o(count)
  );

  sfifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .wr_addr_i(wr_addr), .rd_addr_i(rd_addr), .data_i, .data_o
  );

  sfifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni, .count_i(count), .ae_ofs_i, .af_ofs_i,
    .empty_no, .almost_empty_no, .full_no, .almost_full_no
  );

  p_reset_out_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!rst_ni || (data_o == '0 && !empty_no && full_no)));
endmodule

// File: tb/tb_sync_fifo_thresh.sv
module tb_sync_fifo_thresh;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 9;
  localparam int DEPTH  = 512;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en1_ni = 1'b1, wr_en2_i = 1'b1, rd_en1_ni = 1'b1, rd_en2_ni = 1'b1;
  logic [DATA_W-1:0] data_i = '0;
  logic [AW-1:0] ae_ofs_i = AW'(7), af_ofs_i = AW'(7);
  logic [DATA_W-1:0] data_o;
  logic ofs_wr_o, ofs_rd_o, empty_no, almost_empty_no, full_no, almost_full_no;

  int total = 0, bad = 0;
  bit load_m = 1'b0;
  bit done = 1'b0;
  logic [DATA_W-1:0] exp_q [$];
  logic [DATA_W-1:0] exp_dout = '0;
  int wcnt = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_fifo_thresh #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (.clk_i(clk), .*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_flags();
    int c = exp_q.size();
    chk(empty_no == (c != 0), "R6 empty_no", empty_no, c != 0);
    chk(full_no == (c != DEPTH), "R9 full_no", full_no, c != DEPTH);
    chk(almost_empty_no == (c >= int'(ae_ofs_i) + 1), "R8 almost_empty_no",
        almost_empty_no, c >= int'(ae_ofs_i) + 1);
    chk(almost_full_no == !(c >= DEPTH - int'(af_ofs_i)), "R7 almost_full_no",
        almost_full_no, !(c >= DEPTH - int'(af_ofs_i)));
    chk(data_o == exp_dout, "R4 data_o", data_o, exp_dout);
  endtask

  // driver: applies one cycle of stimulus and updates the scoreboard queue
  task automatic step(input logic w1, input logic w2, input logic r1, input logic r2);
    bit do_push, do_pop, e_ow, e_or;
    wr_en1_ni = w1; wr_en2_i = w2; rd_en1_ni = r1; rd_en2_ni = r2;
    data_i = DATA_W'(wcnt * 37 + 5);
    #1;
    e_ow = load_m && !w1 && !w2;
    e_or = load_m && !w2 && !r1 && !r2;
    chk(ofs_wr_o == e_ow, load_m ? "R3 ofs_wr_o" : "R2 ofs_wr_o", ofs_wr_o, e_ow);
    chk(ofs_rd_o == e_or, load_m ? "R10 ofs_rd_o" : "R2 ofs_rd_o", ofs_rd_o, e_or);
    do_push = !w1 && w2 && exp_q.size() < DEPTH;
    do_pop  = !r1 && !r2 && !(load_m && !w2) && exp_q.size() > 0;
    @(posedge clk);
    if (do_pop) exp_dout = exp_q.pop_front();
    if (do_push) begin
      exp_q.push_back(data_i);
      wcnt++;
    end
    @(negedge clk);
    check_flags();
  endtask

  task automatic do_reset(input bit dual);
    @(negedge clk);
    rst_ni = 1'b0; wr_en1_ni = 1'b1; rd_en1_ni = 1'b1; rd_en2_ni = 1'b1;
    wr_en2_i = dual;
    repeat (3) @(negedge clk);
    chk(data_o == '0 && !empty_no && !almost_empty_no && full_no && almost_full_no,
        "R1 reset flags", {data_o, empty_no, almost_empty_no, full_no, almost_full_no}, 3);
    rst_ni = 1'b1;
    load_m = !dual;
    exp_q.delete();
    exp_dout = '0;
    wr_en2_i = 1'b1;
    @(negedge clk);
    check_flags();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0;
    do_reset(1'b1);
    // R5: read on empty ignored
    step(1, 1, 0, 0);
    // R2: second enable low blocks write in dual mode
    step(0, 0, 1, 1);
    chk(exp_q.size() == 0 && !empty_no, "R2 no write", empty_no, 0);
    for (int i = 0; i < 20; i++) step(0, 1, 1, 1);
    // R4: one read enable high holds output
    step(1, 1, 1, 0);
    step(1, 1, 0, 1);
    step(1, 1, 0, 0);
    // R11: simultaneous read and write
    c0 = exp_q.size();
    step(0, 1, 0, 0);
    chk(exp_q.size() == c0 && empty_no && full_no, "R11 count kept", exp_q.size(), c0);
    // fill to full, push past full, read+write at full
    while (exp_q.size() < DEPTH) step(0, 1, 1, 1);
    chk(!full_no && !almost_full_no, "R9 full reached", full_no, 0);
    step(0, 1, 1, 1);
    step(0, 1, 1, 1);
    step(0, 1, 0, 0);
    step(0, 1, 1, 1);
    while (exp_q.size() > 0) step(1, 1, 0, 0);
    step(1, 1, 0, 0);
    // extreme offsets
    ae_ofs_i = '0; af_ofs_i = AW'(DEPTH - 2);
    @(negedge clk);
    check_flags();
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1);
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0);
    ae_ofs_i = AW'(7); af_ofs_i = AW'(7);
    // load mode
    do_reset(1'b0);
    for (int i = 0; i < 10; i++) step(0, 1, 1, 1);
    c0 = exp_q.size();
    step(0, 0, 1, 1);
    chk(exp_q.size() == c0 && empty_no, "R3 offset write no push", exp_q.size(), c0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    step(1, 1, 0, 0);
    step(0, 1, 0, 0);
    while (exp_q.size() > 0) step(1, 1, 0, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule